// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This block turns a virtual address into a physical address. The virtual address splits into two parts. The low 12 bits are the offset inside a 4 KB page, and the bits above them are the virtual page number. On a translation the offset passes through unchanged, and the page number is replaced by a physical frame number. Recently used table entries are kept in a small fully associative lookaside store. Every slot's tag is compared against the page number in the same cycle, so a hit answers without touching memory.

On a miss, a hardware walker computes the entry address as the table base plus the page number. It reads that single-level table entry over a request/valid memory port. A valid entry is installed in the lookaside store, replacing slots in round-robin order. The unit then checks the entry. A non-resident page raises a page fault. An access that the entry's permission bits forbid raises a protection fault. The first permitted write to a page whose modified bit is clear sets that bit in the cached copy and writes the updated entry back to the table. The requester holds its request until the unit pulses ready together with the result.

Top module: `xlate_unit`

## Requirements
- R1: A successful translation returns respPaddr = {frame number, offset}, where the offset is the low 12 bits of the virtual address, unchanged.
- R2: A request whose page number is present in the lookaside store pulses ready in the cycle after the request is accepted and makes no memory access, unless the R7 write-back applies.
- R3: A request that misses makes exactly one memory read, at address ptBase + page number. A valid fetched entry is installed, so the next request to the same page hits. No two slots ever match the same page.
- R4: A table entry is 12 bits wide. Bits [7:0] hold the frame number, bit 8 is valid (resident), bit 9 is modified, bit 10 allows reads and bit 11 allows writes.
- R5: A fetched entry with bit 8 clear gives pageFault with respPaddr zero, and the entry is not installed, so a repeat of the request walks again.
- R6: A read to an entry with bit 10 clear, or a write to an entry with bit 11 clear, gives protFault with respPaddr zero and no table write.
- R7: A permitted write to an entry with bit 9 clear makes exactly one memory write, at the entry's own table address, of the entry with bit 9 set. Later writes to that page make no further table write.
- R8: The store has 8 slots, filled in install order. The ninth install after reset or flush evicts the page installed first.
- R9: Holding flushAll high for a cycle empties the store, so the next request to any page walks the table.
- R10: ready is high for one cycle per request, and in that cycle exactly one of success, pageFault and protFault holds.
- R11: Once memReq rises, memReq, memWe, memAddr and memWdata stay stable until the cycle in which memValid is high.
- R12: After reset, ready, memReq, memWe, pageFault, protFault and respPaddr are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Clears every entry of the lookaside store |
| reqValid | input | 1 | Translation request; held until ready |
| reqVaddr | input | 20 | Virtual address: page number [19:12], offset [11:0] |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| ptBase | input | 16 | Page-table base address |
| ready | output | 1 | One-cycle pulse marking the result |
| respPaddr | output | 20 | Physical address; zero on a fault |
| pageFault | output | 1 | Page not resident (valid only with ready) |
| protFault | output | 1 | Access not permitted (valid only with ready) |
| memReq | output | 1 | Memory request, held until memValid |
| memWe | output | 1 | 1 = table write-back, 0 = table read |
| memAddr | output | 16 | Table entry address |
| memWdata | output | 12 | Entry data for the write-back |
| memValid | input | 1 | Memory completes the request this cycle |
| memRdata | input | 12 | Entry read from the table |

## Verification
The bench sweeps all 256 page numbers against a table whose entries are computed arithmetically. It mixes reads and writes, varies memory latency, and uses a reference lookaside model to predict hit or miss, the fault kind and the memory traffic. The corners it targets are these:
- A non-resident entry must not be cached. A design that cached it would skip the second walk, so the read count would come out short.
- A write-back must go to the entry's own address, and only once. A design that got this wrong would leave the final table contents different from the expected table, or would show an extra write.
- A flush, and round-robin eviction past the eighth page, must force a fresh walk. A design that kept stale tags would show a missing read, and a late ready pulse on a hit would break the one-cycle latency check.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_WBACK,
    ST_RESP
  } xstate_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic accept;   // latch request address and direction
    logic loadCur;  // latch candidate entry as current entry
    logic install;  // write candidate entry into round-robin slot
    logic markMod;  // set modified bit (installed slot or hit slot)
    logic selWalk;  // candidate entry comes from memory, not from a hit
  } dpCtrl_t;

endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 8,
  parameter int MEM_AW = 16,
  parameter int TLB_N  = 8,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int PTE_W = PFN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              flushAll,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [MEM_AW-1:0] ptBase,
  input  logic [PTE_W-1:0]  memRdata,
  output logic              hit,
  output logic [PTE_W-1:0]  candPte,
  output logic              curWrite,
  output logic [MEM_AW-1:0] memAddr,
  output logic [PTE_W-1:0]  memWdata,
  output logic [PA_W-1:0]   xlatePaddr
);

  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int M_BIT = PFN_W + 1;

  logic [VPN_W-1:0] tagQ [TLB_N];
  logic [PTE_W-1:0] pteQ [TLB_N];
  logic [TLB_N-1:0] vldQ;
  logic [IDX_W-1:0] rrPtr;

  logic [VA_W-1:0]  curVa;
  logic             curWr;
  logic [PTE_W-1:0] curPte;

  logic [TLB_N-1:0] hitVec;
  logic [IDX_W-1:0] hitIdx;
  logic [PTE_W-1:0] hitPte;
  logic [PTE_W-1:0] pteIn;
  logic [VPN_W-1:0] reqVpn;
  logic [VPN_W-1:0] curVpn;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];
  assign curVpn = curVa[VA_W-1:OFF_W];

  // Parallel tag compare across all slots.
  for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
    assign hitVec[g] = vldQ[g] && (tagQ[g] == reqVpn);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < TLB_N; i++) begin
      if (hitVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign hit     = |hitVec;
  assign hitPte  = pteQ[hitIdx];
  assign candPte = ctl.selWalk ? memRdata : hitPte;

  always_comb begin
    pteIn        = candPte;
    pteIn[M_BIT] = candPte[M_BIT] | ctl.markMod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ   <= '0;
      rrPtr  <= '0;
      curVa  <= '0;
      curWr  <= 1'b0;
      curPte <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        tagQ[i] <= '0;
        pteQ[i] <= '0;
      end
    end else begin
      if (ctl.accept) begin
        curVa <= reqVaddr;
        curWr <= reqWrite;
      end
      if (ctl.loadCur) curPte <= candPte;
      if (flushAll) begin
        vldQ <= '0;
      end else if (ctl.install) begin
        vldQ[rrPtr] <= 1'b1;
        tagQ[rrPtr] <= curVpn;
        pteQ[rrPtr] <= pteIn;
        rrPtr       <= (rrPtr == IDX_W'(TLB_N - 1)) ? '0 : rrPtr + 1'b1;
      end else if (ctl.markMod) begin
        pteQ[hitIdx][M_BIT] <= 1'b1;
      end
    end
  end

  assign curWrite          = curWr;
  assign memAddr           = ptBase + MEM_AW'(curVpn);
  always_comb begin
    memWdata        = curPte;
    memWdata[M_BIT] = 1'b1;
  end
  assign xlatePaddr = {curPte[PFN_W-1:0], curVa[OFF_W-1:0]};

  // R3: refill never creates a second slot for the same page
  assert_tag_unique_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R9: a flush leaves no slot valid
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (vldQ == '0));

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int PFN_W  = 8,
  localparam int PTE_W = PFN_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             hit,
  input  logic [PTE_W-1:0] candPte,
  input  logic             curWrite,
  input  logic             memValid,
  output dpCtrl_t          ctl,
  output logic             memReq,
  output logic             memWe,
  output logic             ready,
  output logic             pageFault,
  output logic             protFault,
  output logic             respOk
);

  localparam int V_BIT = PFN_W;
  localparam int M_BIT = PFN_W + 1;
  localparam int R_BIT = PFN_W + 2;
  localparam int W_BIT = PFN_W + 3;

  xstate_t state, nxt;
  logic pfQ, prQ;
  logic flagLoad, nPf, nPr;
  logic isWr, pteValid, permOk, needWb;

  always_comb begin
    isWr     = (state == ST_WALK) ? curWrite : reqWrite;
    pteValid = candPte[V_BIT];
    permOk   = isWr ? candPte[W_BIT] : candPte[R_BIT];
    needWb   = isWr && !candPte[M_BIT];
  end

  always_comb begin
    ctl      = '0;
    nxt      = state;
    flagLoad = 1'b0;
    nPf      = 1'b0;
    nPr      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          if (hit) begin
            ctl.loadCur = 1'b1;
            flagLoad    = 1'b1;
            if (!permOk) begin
              nPr = 1'b1;
              nxt = ST_RESP;
            end else if (needWb) begin
              ctl.markMod = 1'b1;
              nxt         = ST_WBACK;
            end else begin
              nxt = ST_RESP;
            end
          end else begin
            nxt = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        ctl.selWalk = 1'b1;
        if (memValid) begin
          ctl.loadCur = 1'b1;
          flagLoad    = 1'b1;
          if (!pteValid) begin
            nPf = 1'b1;
            nxt = ST_RESP;
          end else begin
            ctl.install = 1'b1;
            if (!permOk) begin
              nPr = 1'b1;
              nxt = ST_RESP;
            end else if (needWb) begin
              ctl.markMod = 1'b1;
              nxt         = ST_WBACK;
            end else begin
              nxt = ST_RESP;
            end
          end
        end
      end
      ST_WBACK: begin
        if (memValid) nxt = ST_RESP;
      end
      ST_RESP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pfQ   <= 1'b0;
      prQ   <= 1'b0;
    end else begin
      state <= nxt;
      if (flagLoad) begin
        pfQ <= nPf;
        prQ <= nPr;
      end
    end
  end

  assign memReq    = (state == ST_WALK) || (state == ST_WBACK);
  assign memWe     = (state == ST_WBACK);
  assign ready     = (state == ST_RESP);
  assign pageFault = ready && pfQ;
  assign protFault = ready && prQ;
  assign respOk    = ready && !pfQ && !prQ;

  // R11: a pending memory request keeps its direction until completed
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memWe)));

  // R10: ready never lasts two cycles
  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R10: exactly one outcome per response
  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> $onehot({respOk, pageFault, protFault}));

  // R7: table write-back only serves a write access
  assert_wb_for_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> curWrite);

endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int OFF_W  = 12,
  parameter int PFN_W  = 8,
  parameter int MEM_AW = 16,
  parameter int TLB_N  = 8,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W,
  localparam int PTE_W = PFN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [MEM_AW-1:0] ptBase,
  output logic              ready,
  output logic [PA_W-1:0]   respPaddr,
  output logic              pageFault,
  output logic              protFault,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [PTE_W-1:0]  memWdata,
  input  logic              memValid,
  input  logic [PTE_W-1:0]  memRdata
);

  dpCtrl_t          ctl;
  logic             hit;
  logic             curWrite;
  logic             respOk;
  logic [PTE_W-1:0] candPte;
  logic [PA_W-1:0]  xlatePaddr;

  xlate_dp #(
    .VPN_W (VPN_W),
    .OFF_W (OFF_W),
    .PFN_W (PFN_W),
    .MEM_AW(MEM_AW),
    .TLB_N (TLB_N)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .flushAll  (flushAll),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .ptBase    (ptBase),
    .memRdata  (memRdata),
    .hit       (hit),
    .candPte   (candPte),
    .curWrite  (curWrite),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .xlatePaddr(xlatePaddr)
  );

  xlate_ctrl #(
    .PFN_W(PFN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .hit      (hit),
    .candPte  (candPte),
    .curWrite (curWrite),
    .memValid (memValid),
    .ctl      (ctl),
    .memReq   (memReq),
    .memWe    (memWe),
    .ready    (ready),
    .pageFault(pageFault),
    .protFault(protFault),
    .respOk   (respOk)
  );

  assign respPaddr = respOk ? xlatePaddr : '0;

  // R11: address and write data hold while the memory request waits
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> ($stable(memAddr) && $stable(memWdata)));

  // R5: a faulting response carries no physical address
  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ready && (pageFault || protFault)) |-> (respPaddr == '0));

endmodule

// File: tb/xlate_unit_bench.sv
`timescale 1ns/1ps
module xlate_unit_bench;

  localparam logic [15:0] PT_BASE = 16'h0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushAll = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        ready, pageFault, protFault, memReq, memWe;
  logic [19:0] respPaddr;
  logic [15:0] memAddr;
  logic [11:0] memWdata;
  logic        memValid;
  logic [11:0] memRdata;

  always #2.5 clk = ~clk;

  xlate_unit u_xlate_unit (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .ptBase(PT_BASE),
    .ready(ready), .respPaddr(respPaddr), .pageFault(pageFault),
    .protFault(protFault), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memValid(memValid),
    .memRdata(memRdata)
  );

  int testsRun = 0;
  int testsFailed = 0;

  // R4 entry layout: [7:0] frame, 8 valid, 9 modified, 10 read ok, 11 write ok
  function automatic logic [11:0] initPte(input int v);
    logic [11:0] p;
    p[7:0] = 8'(v) ^ 8'hA5;
    p[8]   = (v % 7) != 3;
    p[9]   = ((v >> 2) & 1) == 1;
    p[10]  = (v % 5) != 4;
    p[11]  = (v % 3) != 0;
    return p;
  endfunction

  // Memory model for the page table
  logic [11:0] ptMem [256];
  int memLat = 0;
  int memCnt = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  int badAddr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memRdata <= '0;
      memCnt = 0;
      for (int i = 0; i < 256; i++) ptMem[i] <= initPte(i);
    end else if (memValid) begin
      memValid <= 1'b0;
      memCnt = 0;
    end else if (memReq) begin
      if (memCnt >= memLat) begin
        memValid <= 1'b1;
        if (memAddr < PT_BASE || memAddr >= PT_BASE + 16'd256) begin
          badAddr++;
        end else if (memWe) begin
          ptMem[memAddr - PT_BASE] <= memWdata;
          wrCnt++;
        end else begin
          memRdata <= ptMem[memAddr - PT_BASE];
          rdCnt++;
        end
      end else begin
        memCnt++;
      end
    end
  end

  // Reference lookaside model
  logic [7:0]  refTag [8];
  logic        refVld [8];
  int          refRr = 0;
  logic [11:0] expPte [256];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
    for (int i = 0; i < 8; i++) refVld[i] = 1'b0;
    refRr = 0;
  endtask

  task automatic doXlate(input int vpn, input int off, input bit wr, input string tag);
    bit refHit;
    int rd0, wr0, cyc;
    logic [11:0] p;
    bit expPf, expPr, expWb, perm;
    logic [19:0] expPa;
    refHit = 1'b0;
    for (int i = 0; i < 8; i++)
      if (refVld[i] && refTag[i] == 8'(vpn)) refHit = 1'b1;
    p     = expPte[vpn];
    expPf = !refHit && !p[8];
    perm  = wr ? p[11] : p[10];
    expPr = !expPf && !perm;
    expWb = !expPf && !expPr && wr && !p[9];
    expPa = (expPf || expPr) ? 20'h0 : {p[7:0], 12'(off)};

    @(negedge clk);
    memLat   = vpn % 3;
    rd0      = rdCnt;
    wr0      = wrCnt;
    reqVaddr = {8'(vpn), 12'(off)};
    reqWrite = wr;
    reqValid = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready && cyc < 60);
    reqValid = 1'b0;

    check(ready == 1'b1, "R10", {tag, " ready seen"}, ready, 1);
    check(pageFault == expPf, "R5", {tag, " pageFault"}, pageFault, expPf);
    check(protFault == expPr, "R6", {tag, " protFault"}, protFault, expPr);
    check(respPaddr == expPa, "R1", {tag, " paddr R4 fields"}, respPaddr, expPa);
    if (refHit) begin
      check(rdCnt == rd0, "R2", {tag, " no read on hit"}, rdCnt - rd0, 0);
      if (!expWb) check(cyc == 1, "R2", {tag, " hit latency"}, cyc, 1);
    end else begin
      check(rdCnt == rd0 + 1, "R3", {tag, " one walk read"}, rdCnt - rd0, 1);
    end
    check(wrCnt == wr0 + (expWb ? 1 : 0), "R7", {tag, " write-back count"},
          wrCnt - wr0, expWb ? 1 : 0);

    // Reference update
    if (!refHit && p[8]) begin
      refTag[refRr] = 8'(vpn);
      refVld[refRr] = 1'b1;
      refRr = (refRr + 1) % 8;
    end
    if (expWb) expPte[vpn][9] = 1'b1;

    @(negedge clk);
    check(ready == 1'b0, "R10", {tag, " ready single pulse"}, ready, 0);
  endtask

  int firstV [9];

  initial begin
    for (int i = 0; i < 256; i++) expPte[i] = initPte(i);
    for (int i = 0; i < 8; i++) refVld[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 0 && memReq == 0 && memWe == 0, "R12", "ready/memReq after reset",
          {ready, memReq, memWe}, 0);
    check(pageFault == 0 && protFault == 0 && respPaddr == 0, "R12",
          "result outputs after reset", {pageFault, protFault, respPaddr}, 0);
    rstN = 1'b1;

    // Sweep every page: reads, then writes, then revisit recent pages
    for (int v = 0; v < 256; v++) doXlate(v, (v * 273) & 12'hFFF, 1'b0, "sweep-rd");
    for (int v = 0; v < 256; v++) doXlate(v, (v * 91 + 7) & 12'hFFF, v[0], "sweep-mix");
    for (int v = 248; v < 256; v++) doXlate(v, v & 12'hFFF, 1'b1, "recent-wr");
    for (int v = 248; v < 256; v++) doXlate(v, 12'hFFF, 1'b1, "recent-wr2");

    // R9: flush forces a walk on a page that was cached
    doFlush();
    doXlate(254, 12'h000, 1'b0, "R9 after flush");

    // R8: nine valid distinct pages after flush; the first is then evicted
    doFlush();
    begin
      int n = 0;
      for (int v = 20; v < 256 && n < 9; v++)
        if (initPte(v)[8]) begin firstV[n] = v; n++; end
    end
    for (int k = 0; k < 9; k++) doXlate(firstV[k], 12'h123, 1'b0, "R8 fill");
    doXlate(firstV[1], 12'h456, 1'b0, "R8 survivor");
    doXlate(firstV[0], 12'h789, 1'b0, "R8 evicted");

    // R5: invalid page walks again each time
    doXlate(3, 12'hABC, 1'b0, "R5 invalid");
    doXlate(3, 12'hABC, 1'b1, "R5 invalid again");

    repeat (4) @(negedge clk);
    begin
      int mism = 0;
      for (int i = 0; i < 256; i++) if (ptMem[i] !== expPte[i]) mism++;
      check(mism == 0, "R7", "table contents after write-backs", mism, 0);
    end
    check(badAddr == 0, "R3", "table accesses inside table range", badAddr, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule